// File: doc/BRIEF.md
# DMA Control and Status Register Bank

This block is the software-visible register bank that sits beside a packet DMA engine pair. It holds the bus-mode word, the control word, the interrupt-enable mask, the transmit and receive descriptor-list base addresses with their current pointers, and a sticky event status word. Software reaches it through a word-addressed bus: one write port, and a read port that returns data in the same cycle as the address.

The transmit and receive engines report events by pulsing bits of a set vector. Software acknowledges an event by writing 1 to its status bit. A single level interrupt follows the masked status. Writing a list base address also rewinds the matching current pointer. The engines move a current pointer forward through a load port. Writing either poll-demand word stores nothing and gives a one-cycle kick to its engine.

Top module: `dma_csr_regs`

## Requirements
- R1: `irq` is high exactly when at least one bit is set in both the status word and the interrupt-enable word. It reflects a register write or a set pulse from the first clock edge after that event.
- R2: A write to the status word (word 0x3C5) clears every status bit whose write-data bit is 1 and leaves every other status bit unchanged.
- R3: A 1 on `stat_set` sets the matching status bit at the next edge, but only for the implemented bits 0, 1, 2, 4, 5, 6, 7, 15 and 16 (mask 0x000180F7). The other bits always read 0. When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: A write to the bus-mode word (0x3C0) stores the write data with bit 0 forced to 0. `bus_mode_o` and reads show the stored value.
- R5: The version word (0x008) always reads 0x00001012, and writes to it have no effect.
- R6: A write to the receive base word (0x3C3) or the transmit base word (0x3C4) loads the data into both that base and its current pointer. The receive current pointer reads at 0x3D3 and the transmit current pointer at 0x3D2. If an engine load hits the same pointer in the same cycle, the base write wins.
- R7: An engine load (`tx_cur_ld`/`rx_cur_ld`) replaces the current pointer with the supplied value at the next edge. Bus writes to the current-pointer words are ignored.
- R8: A write to 0x3C1 makes `tx_kick` high for exactly the next cycle, and a write to 0x3C2 does the same for `rx_kick`. Both poll words read 0.
- R9: The control word (0x3C6) and the interrupt-enable word (0x3C7) store and read back all 32 bits. The control word drives `ctrl_o`.
- R10: Reads of any unmapped word return 0, and writes to unmapped words change no register.
- R11: After reset, every stored register reads 0 and `irq`, `tx_kick` and `rx_kick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Write strobe |
| csr_addr | input | ADDR_W (10) | Word address for both read and write |
| csr_wdata | input | DATA_W (32) | Write data |
| csr_rdata | output | DATA_W (32) | Read data for `csr_addr`, same cycle |
| stat_set | input | DATA_W (32) | Status set pulses from the engines |
| tx_cur_ld | input | 1 | Transmit engine loads its current pointer |
| tx_cur_val | input | DATA_W (32) | New transmit current pointer |
| rx_cur_ld | input | 1 | Receive engine loads its current pointer |
| rx_cur_val | input | DATA_W (32) | New receive current pointer |
| tx_kick | output | 1 | One-cycle transmit poll pulse |
| rx_kick | output | 1 | One-cycle receive poll pulse |
| bus_mode_o | output | DATA_W (32) | Stored bus-mode word |
| ctrl_o | output | DATA_W (32) | Stored control word |
| tx_cur_o | output | DATA_W (32) | Transmit current pointer |
| rx_cur_o | output | DATA_W (32) | Receive current pointer |
| irq | output | 1 | Level interrupt |

## Verification
A fixed-seed random mix runs throughout. It combines sparse set pulses, random clearing writes, random enable masks and engine pointer loads. After every step the interrupt is compared with a bench model, so a wrong mask, a missed clear or a stale enable each show up as a mismatch. Directed cases cover the collisions that random stimulus rarely hits: a set and a clear on the same bit in one cycle, and a base write together with an engine load. Further directed cases cover writes to read-only and unmapped words, followed by a readback sweep that shows nothing else moved. A reserved status bit driven high must never appear, which separates the implemented mask from a plain sticky register.

// File: rtl/dma_csr_pkg.sv
// Shared constants and types for the DMA register bank.
// Assumes word addresses fit in 10 bits.
package dma_csr_pkg;

    localparam int unsigned A_VERSION = 'h008;
    localparam int unsigned A_BUSMODE = 'h3C0;
    localparam int unsigned A_TXPOLL  = 'h3C1;
    localparam int unsigned A_RXPOLL  = 'h3C2;
    localparam int unsigned A_RXBASE  = 'h3C3;
    localparam int unsigned A_TXBASE  = 'h3C4;
    localparam int unsigned A_STATUS  = 'h3C5;
    localparam int unsigned A_CTRL    = 'h3C6;
    localparam int unsigned A_INTEN   = 'h3C7;
    localparam int unsigned A_TXCUR   = 'h3D2;
    localparam int unsigned A_RXCUR   = 'h3D3;

    localparam logic [31:0] VERSION_WORD   = 32'h0000_1012;
    // implemented status bits: 0,1,2,4,5,6,7,15,16
    localparam logic [31:0] STAT_IMPL_MASK = 32'h0001_80F7;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_TX  = 0;
    localparam int unsigned CH_RX  = 1;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_VERSION,
        RG_BUSMODE,
        RG_TXPOLL,
        RG_RXPOLL,
        RG_RXBASE,
        RG_TXBASE,
        RG_STATUS,
        RG_CTRL,
        RG_INTEN,
        RG_TXCUR,
        RG_RXCUR
    } reg_id_e;

endpackage

// File: rtl/dma_csr_decode.sv
// Address decoder: maps a word address to a register identifier.
// Assumes the caller qualifies writes itself; pure combinational.
module dma_csr_decode
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           sel
);

    // Purpose: translate the address into one register id, RG_NONE if unmapped.
    always_comb begin
        sel = RG_NONE;
        if      (addr == ADDR_W'(A_VERSION)) sel = RG_VERSION;
        else if (addr == ADDR_W'(A_BUSMODE)) sel = RG_BUSMODE;
        else if (addr == ADDR_W'(A_TXPOLL))  sel = RG_TXPOLL;
        else if (addr == ADDR_W'(A_RXPOLL))  sel = RG_RXPOLL;
        else if (addr == ADDR_W'(A_RXBASE))  sel = RG_RXBASE;
        else if (addr == ADDR_W'(A_TXBASE))  sel = RG_TXBASE;
        else if (addr == ADDR_W'(A_STATUS))  sel = RG_STATUS;
        else if (addr == ADDR_W'(A_CTRL))    sel = RG_CTRL;
        else if (addr == ADDR_W'(A_INTEN))   sel = RG_INTEN;
        else if (addr == ADDR_W'(A_TXCUR))   sel = RG_TXCUR;
        else if (addr == ADDR_W'(A_RXCUR))   sel = RG_RXCUR;
    end

endmodule

// File: rtl/dma_csr_status.sv
// Sticky event status word: bits set from hardware pulses and are
// cleared by writing 1. A set pulse beats a clear on the same bit.
// Assumes set pulses are synchronous to clk.
module dma_csr_status #(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] IMPL_MASK = 32'h0001_80F7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    input  logic [DATA_W-1:0] set_bits,
    output logic [DATA_W-1:0] stat_q
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'(IMPL_MASK);

    logic [DATA_W-1:0] kept;

    // Purpose: drop the bits software acknowledges this cycle.
    always_comb begin
        kept = clr_en ? (stat_q & ~clr_bits) : stat_q;
    end

    // Purpose: hold the status word, merging new events over the clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (kept | set_bits) & MASK;
        end
    end

endmodule

// File: rtl/dma_csr_ptr.sv
// One descriptor-list channel: a base register and a current pointer.
// A base write rewinds the current pointer and wins over an engine load.
// Assumes loads are single-cycle strobes.
module dma_csr_ptr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [DATA_W-1:0] base_val,
    input  logic              eng_ld,
    input  logic [DATA_W-1:0] eng_val,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cur_q
);

    // Purpose: store the list base written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_wr) begin
            base_q <= base_val;
        end
    end

    // Purpose: track the current pointer; a rewind has priority over the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (base_wr) begin
            cur_q <= base_val;
        end else if (eng_ld) begin
            cur_q <= eng_val;
        end
    end

endmodule

// File: rtl/dma_csr_irq.sv
// Interrupt combine: a level output from status masked by enable.
// Assumes both inputs are registered, so the output is glitch-safe.
module dma_csr_irq #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] enable,
    output logic              irq
);

    // Purpose: raise the line when any enabled event is pending.
    always_comb begin
        irq = |(stat & enable);
    end

endmodule

// File: rtl/dma_csr_regs.sv
// DMA register bank top: decodes the bus, holds bus-mode, control and
// enable words, wires the status word, two pointer channels and the
// interrupt combine. Reads are combinational; writes take effect at the edge.
// Assumes one bus access per cycle with a shared read/write address.
module dma_csr_regs
    import dma_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic [DATA_W-1:0] stat_set,
    input  logic              tx_cur_ld,
    input  logic [DATA_W-1:0] tx_cur_val,
    input  logic              rx_cur_ld,
    input  logic [DATA_W-1:0] rx_cur_val,
    output logic              tx_kick,
    output logic              rx_kick,
    output logic [DATA_W-1:0] bus_mode_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] tx_cur_o,
    output logic [DATA_W-1:0] rx_cur_o,
    output logic              irq
);

    localparam logic [DATA_W-1:0] STICK_MASK = ~DATA_W'(1);

    reg_id_e           sel;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] inten_q;
    logic [DATA_W-1:0] bus_mode_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              tx_kick_q;
    logic              rx_kick_q;

    logic [NUM_CH-1:0] base_wr;
    logic [NUM_CH-1:0] eng_ld;
    logic [DATA_W-1:0] eng_val [NUM_CH];
    logic [DATA_W-1:0] base_q  [NUM_CH];
    logic [DATA_W-1:0] cur_q   [NUM_CH];

    dma_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (csr_addr),
        .sel  (sel)
    );

    dma_csr_status #(.DATA_W(DATA_W), .IMPL_MASK(STAT_IMPL_MASK)) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (csr_wr && sel == RG_STATUS),
        .clr_bits (csr_wdata),
        .set_bits (stat_set),
        .stat_q   (stat_q)
    );

    // Purpose: route the per-channel write and load strobes.
    always_comb begin
        base_wr[CH_TX]  = csr_wr && sel == RG_TXBASE;
        base_wr[CH_RX]  = csr_wr && sel == RG_RXBASE;
        eng_ld[CH_TX]   = tx_cur_ld;
        eng_ld[CH_RX]   = rx_cur_ld;
        eng_val[CH_TX]  = tx_cur_val;
        eng_val[CH_RX]  = rx_cur_val;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dma_csr_ptr #(.DATA_W(DATA_W)) i_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_wr  (base_wr[ch]),
            .base_val (csr_wdata),
            .eng_ld   (eng_ld[ch]),
            .eng_val  (eng_val[ch]),
            .base_q   (base_q[ch]),
            .cur_q    (cur_q[ch])
        );
    end

    dma_csr_irq #(.DATA_W(DATA_W)) i_irq (
        .stat   (stat_q),
        .enable (inten_q),
        .irq    (irq)
    );

    // Purpose: plain software words (bus mode with bit 0 dropped, control, enable).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_mode_q <= '0;
            ctrl_q     <= '0;
            inten_q    <= '0;
        end else if (csr_wr) begin
            if (sel == RG_BUSMODE) bus_mode_q <= csr_wdata & STICK_MASK;
            if (sel == RG_CTRL)    ctrl_q     <= csr_wdata;
            if (sel == RG_INTEN)   inten_q    <= csr_wdata;
        end
    end

    // Purpose: one-cycle poll kicks from writes to the poll words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_kick_q <= 1'b0;
            rx_kick_q <= 1'b0;
        end else begin
            tx_kick_q <= csr_wr && sel == RG_TXPOLL;
            rx_kick_q <= csr_wr && sel == RG_RXPOLL;
        end
    end

    // Purpose: same-cycle read mux; unmapped and poll words read zero.
    always_comb begin
        case (sel)
            RG_VERSION: csr_rdata = DATA_W'(VERSION_WORD);
            RG_BUSMODE: csr_rdata = bus_mode_q;
            RG_RXBASE:  csr_rdata = base_q[CH_RX];
            RG_TXBASE:  csr_rdata = base_q[CH_TX];
            RG_STATUS:  csr_rdata = stat_q;
            RG_CTRL:    csr_rdata = ctrl_q;
            RG_INTEN:   csr_rdata = inten_q;
            RG_TXCUR:   csr_rdata = cur_q[CH_TX];
            RG_RXCUR:   csr_rdata = cur_q[CH_RX];
            default:    csr_rdata = '0;
        endcase
    end

    assign tx_kick    = tx_kick_q;
    assign rx_kick    = rx_kick_q;
    assign bus_mode_o = bus_mode_q;
    assign ctrl_o     = ctrl_q;
    assign tx_cur_o   = cur_q[CH_TX];
    assign rx_cur_o   = cur_q[CH_RX];

endmodule

// File: rtl/dma_csr_checks.sv
// Assertion checker for the DMA register bank, bound to the top.
// Assumes the synchronous active-low reset of the top.
module dma_csr_checks
    import dma_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [DATA_W-1:0] csr_wdata,
    input logic [DATA_W-1:0] csr_rdata,
    input logic [DATA_W-1:0] stat_set,
    input logic              tx_kick,
    input logic [DATA_W-1:0] tx_cur_o,
    input logic              irq,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] inten_q
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'(STAT_IMPL_MASK);

    a_r1_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q != '0));

    a_r1_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (inten_q != '0));

    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr == ADDR_W'(A_STATUS))
        |=> ((stat_q & $past(csr_wdata & ~stat_set)) == '0));

    a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_set & MASK) != '0)
        |=> ((stat_q & $past(stat_set & MASK)) == $past(stat_set & MASK)));

    a_r4_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_W'(A_BUSMODE)) |-> !csr_rdata[0]);

    a_r5_version: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_W'(A_VERSION)) |-> (csr_rdata == DATA_W'(VERSION_WORD)));

    a_r6_base_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr == ADDR_W'(A_TXBASE)) |=> (tx_cur_o == $past(csr_wdata)));

    a_r8_kick_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr == ADDR_W'(A_TXPOLL)) |=> tx_kick);

    a_r8_kick_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |-> $past(csr_wr && csr_addr == ADDR_W'(A_TXPOLL)));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_W'('h3FF)) |-> (csr_rdata == '0));

endmodule

bind dma_csr_regs dma_csr_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .stat_set  (stat_set),
    .tx_kick   (tx_kick),
    .tx_cur_o  (tx_cur_o),
    .irq       (irq),
    .stat_q    (stat_q),
    .inten_q   (inten_q)
);

// File: tb/test_dma_csr_regs.sv
module test_dma_csr_regs;

    localparam int DW = 32;
    localparam int AW = 10;
    localparam logic [31:0] MASK = 32'h0001_80F7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [DW-1:0] csr_wdata = '0;
    logic [DW-1:0] csr_rdata;
    logic [DW-1:0] stat_set = '0;
    logic          tx_cur_ld = 1'b0;
    logic [DW-1:0] tx_cur_val = '0;
    logic          rx_cur_ld = 1'b0;
    logic [DW-1:0] rx_cur_val = '0;
    logic          tx_kick, rx_kick, irq;
    logic [DW-1:0] bus_mode_o, ctrl_o, tx_cur_o, rx_cur_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [31:0] m_stat, m_inten, m_bus, m_ctrl, m_rxb, m_txb, m_rxc, m_txc;
    logic        m_txk, m_rxk;

    always #5 clk = ~clk;

    dma_csr_regs #(.DATA_W(DW), .ADDR_W(AW)) i_dma_csr_regs (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .stat_set(stat_set),
        .tx_cur_ld(tx_cur_ld), .tx_cur_val(tx_cur_val),
        .rx_cur_ld(rx_cur_ld), .rx_cur_val(rx_cur_val),
        .tx_kick(tx_kick), .rx_kick(rx_kick), .bus_mode_o(bus_mode_o),
        .ctrl_o(ctrl_o), .tx_cur_o(tx_cur_o), .rx_cur_o(rx_cur_o), .irq(irq)
    );

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            10'h008: return 32'h0000_1012;
            10'h3C0: return m_bus;
            10'h3C3: return m_rxb;
            10'h3C4: return m_txb;
            10'h3C5: return m_stat;
            10'h3C6: return m_ctrl;
            10'h3C7: return m_inten;
            10'h3D2: return m_txc;
            10'h3D3: return m_rxc;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        csr_wr = 1'b0; stat_set = '0; tx_cur_ld = 1'b0; rx_cur_ld = 1'b0;
        csr_addr = a;
        #1 chk(tag, csr_rdata, exp_read(a));
    endtask

    task automatic sweep(input string tag);
        rd(10'h008, tag); rd(10'h3C0, tag); rd(10'h3C1, tag); rd(10'h3C2, tag);
        rd(10'h3C3, tag); rd(10'h3C4, tag); rd(10'h3C5, tag); rd(10'h3C6, tag);
        rd(10'h3C7, tag); rd(10'h3D2, tag); rd(10'h3D3, tag); rd(10'h3FF, tag);
    endtask

    // one clocked step; model updated at the edge, outputs checked just after
    task automatic step(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [31:0] set, input logic tl, input logic [31:0] tv,
                        input logic rl, input logic [31:0] rv);
        @(negedge clk);
        csr_wr = wr; csr_addr = a; csr_wdata = d; stat_set = set;
        tx_cur_ld = tl; tx_cur_val = tv; rx_cur_ld = rl; rx_cur_val = rv;
        @(posedge clk);
        if (tl) m_txc = tv;
        if (rl) m_rxc = rv;
        m_txk = wr && a == 10'h3C1;
        m_rxk = wr && a == 10'h3C2;
        if (wr) begin
            case (a)
                10'h3C0: m_bus = d & ~32'h1;
                10'h3C3: begin m_rxb = d; m_rxc = d; end
                10'h3C4: begin m_txb = d; m_txc = d; end
                10'h3C5: m_stat = m_stat & ~d;
                10'h3C6: m_ctrl = d;
                10'h3C7: m_inten = d;
                default: ;
            endcase
        end
        m_stat = (m_stat | set) & MASK;
        #1;
        chk("R1 irq", {31'b0, irq}, {31'b0, |(m_stat & m_inten)});
        chk("R8 tx_kick", {31'b0, tx_kick}, {31'b0, m_txk});
        chk("R8 rx_kick", {31'b0, rx_kick}, {31'b0, m_rxk});
        csr_wr = 1'b0; stat_set = '0; tx_cur_ld = 1'b0; rx_cur_ld = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] addrs [14];
        int unsigned seed;
        seed = $urandom(32'd20240611);
        addrs = '{10'h008, 10'h3C0, 10'h3C1, 10'h3C2, 10'h3C3, 10'h3C4, 10'h3C5,
                  10'h3C6, 10'h3C7, 10'h3D2, 10'h3D3, 10'h3FF, 10'h3C8, 10'h100};
        {m_stat, m_inten, m_bus, m_ctrl, m_rxb, m_txb, m_rxc, m_txc} = '0;
        m_txk = 1'b0; m_rxk = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11 reset state
        sweep("R11 reset");
        chk("R11 irq", {31'b0, irq}, 32'h0);
        chk("R11 kicks", {30'b0, tx_kick, rx_kick}, 32'h0);

        // R4 bit 0 dropped
        step(1, 10'h3C0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
        rd(10'h3C0, "R4 busmode");
        chk("R4 bus_mode_o", bus_mode_o, 32'hDEAD_BEEE);
        // R5 version unwritable
        step(1, 10'h008, 32'h1234_5678, 0, 0, 0, 0, 0);
        rd(10'h008, "R5 version");
        // R9 control and enable
        step(1, 10'h3C6, 32'hA5A5_0F0F, 0, 0, 0, 0, 0);
        chk("R9 ctrl_o", ctrl_o, 32'hA5A5_0F0F);
        step(1, 10'h3C7, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        rd(10'h3C7, "R9 inten");
        // R3 set pulses with reserved bits
        step(0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd(10'h3C5, "R3 mask");
        // R2 partial clear
        step(1, 10'h3C5, 32'h0000_00F0, 0, 0, 0, 0, 0);
        rd(10'h3C5, "R2 partial clear");
        // R3 set beats clear on same bit
        step(1, 10'h3C5, 32'h0001_8007, 32'h0000_0001, 0, 0, 0, 0);
        rd(10'h3C5, "R3 set wins");
        chk("R3 bit0", m_stat & 32'h1, 32'h1);
        // R1 enable off drops irq
        step(1, 10'h3C7, 32'h0, 0, 0, 0, 0, 0);
        // R6 base write and collision with engine load
        step(1, 10'h3C4, 32'h1000_0000, 0, 0, 0, 0, 0);
        chk("R6 tx_cur_o", tx_cur_o, 32'h1000_0000);
        step(1, 10'h3C3, 32'h2000_0000, 0, 0, 0, 1, 32'h2222_2222);
        chk("R6 rx collision", rx_cur_o, 32'h2000_0000);
        // R7 engine load, bus writes to current words ignored
        step(0, 0, 0, 0, 1, 32'h1000_0020, 0, 0);
        chk("R7 tx load", tx_cur_o, 32'h1000_0020);
        step(1, 10'h3D2, 32'h5555_5555, 0, 0, 0, 0, 0);
        step(1, 10'h3D3, 32'h6666_6666, 0, 0, 0, 0, 0);
        rd(10'h3D2, "R7 txcur ro"); rd(10'h3D3, "R7 rxcur ro");
        // R8 poll kicks and reads
        step(1, 10'h3C1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 10'h3C2, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        rd(10'h3C1, "R8 poll reads 0");
        // R10 unmapped writes
        step(1, 10'h3FF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        step(1, 10'h3C8, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        sweep("R10 unmapped");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic [31:0] d, s;
            a = addrs[$urandom % 14];
            d = $urandom;
            if (a == 10'h3C5) d = d & $urandom;
            s = $urandom & $urandom & $urandom;
            step(($urandom % 3) != 0, a, d, s, ($urandom % 5) == 0, $urandom,
                 ($urandom % 5) == 0, $urandom);
            rd(addrs[$urandom % 14], "R2 R3 R9 random readback");
        end
        sweep("R10 final sweep");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule